// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block supervises a backup battery by running a timed load test at a fixed long interval and keeping a warning output that reports a weak battery. Each test closes a load-enable output for a window of clock cycles. During that window it watches a digital comparator flag that is high when the battery sits below its trip level. The analog comparator and the load resistor are outside the block. It only drives the enable and reads the flag.

Tests run only while the main supply is reported valid. After every supply rise a recovery delay passes, and then a test runs at once. That power-up test is the only one that may release an active warning. Tests that come later on the long interval can only set the warning, never clear it. A supply loss aborts any test in progress, drops the load at once and restarts every count. The warning output is an open-drain request: a 1 means pull the line low, and a 0 means release it. The recovery, window and interval lengths are parameters, and their defaults are 200 ms, 1 s and 24 h at 50 MHz.

Top module: `batt_health_mon`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `load_en` is 0 and `warn_pull_low` is 0 (released).
- R2: If `pwr_ok` is sampled high at a clock edge while the monitor is idle, `load_en` stays 0 for the next REC_CYCLES cycles. It rises in the cycle after that.
- R3: A test window keeps `load_en` high for exactly WINDOW_CYCLES consecutive cycles.
- R4: With power held valid, `load_en` is low for exactly INTERVAL_CYCLES cycles between the end of one window and the start of the next.
- R5: `batt_low_raw` = 1 means the battery is below the trip level. The flag passes through two flops. A window counts as failed if the synchronised flag is 1 in any of its cycles. For a one-cycle pulse, this means the raw pulse must be captured no later than the third-to-last clock edge of the window. On a failed window, `warn_pull_low` becomes 1 in the cycle in which `load_en` falls.
- R6: A window on the long interval that finds the battery good leaves `warn_pull_low` unchanged, so a warning that is already set stays set.
- R7: The first window after each power-up sets the warning if it fails and clears it if it passes, even when the warning was already set.
- R8: Flag values that reach the synchronised stage outside a test window have no effect on `warn_pull_low`.
- R9: When `pwr_ok` is 0, `load_en` is 0 in that same cycle, with no register delay. A window cut short by a supply loss leaves `warn_pull_low` unchanged. The warning also keeps its value while power is absent.
- R10: After any supply loss, whether during recovery, a window or an interval, the full recovery delay and the full interval count start again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Main supply valid, synchronous to clk |
| batt_low_raw | input | 1 | Asynchronous comparator flag, 1 = battery below trip level |
| load_en | output | 1 | Connects the test load to the battery |
| warn_pull_low | output | 1 | 1 = pull the open-drain warning line low |

## Verification
Several properties are checked on every cycle: the load is off whenever the supply is invalid, the warning stays frozen while power is missing, and the warning can rise only at the close of a window and fall only at the close of a power-up window. The interval timer is also checked to count down one step per cycle from the value it was loaded with. The remaining behaviour is shown by the bench's scenarios. These cover the exact cycle on which the load rises after recovery, the length of the window and of the interval, and the pulse position that separates a counted flag from an ignored one (every offset in the window is swept). They also cover a power loss partway through a window or through recovery, and power-up retests that find a bad or a good battery.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_RECOVER = 2'd1,
        ST_TEST    = 2'd2,
        ST_WAIT    = 2'd3
    } bhm_state_e;

    typedef struct packed {
        bhm_state_e state;
        logic       warn;      // sticky warning, 1 = pull line low
        logic       first;     // next window is the power-up window
        logic       low_seen;  // flag seen high in the current window
    } bhm_ctrl_s;

endpackage

// File: rtl/bhm_sync.sv
module bhm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/bhm_timer.sv
module bhm_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] start_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = start_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4: a running count falls by one per cycle
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3: a start loads exactly the requested value
    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == $past(start_val)));
endmodule

// File: rtl/bhm_ctrl.sv
module bhm_ctrl
    import bhm_pkg::*;
#(
    parameter int              CW              = 8,
    parameter longint unsigned REC_CYCLES      = 5,
    parameter longint unsigned WINDOW_CYCLES   = 8,
    parameter longint unsigned INTERVAL_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          batt_low,
    input  logic          tmr_expired,
    output logic          tmr_start,
    output logic [CW-1:0] tmr_val,
    output logic          load_en,
    output logic          warn
);
    localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYCLES - 1);
    localparam logic [CW-1:0] WIN_LOAD = CW'(WINDOW_CYCLES - 1);
    localparam logic [CW-1:0] INT_LOAD = CW'(INTERVAL_CYCLES - 1);

    bhm_ctrl_s c_d, c_q;
    logic      verdict_low;

    always_comb begin
        c_d         = c_q;
        tmr_start   = 1'b0;
        tmr_val     = '0;
        verdict_low = c_q.low_seen | batt_low;
        if (!pwr_ok) begin
            c_d.state    = ST_OFF;
            c_d.first    = 1'b1;
            c_d.low_seen = 1'b0;
            tmr_start    = 1'b1;
        end else begin
            unique case (c_q.state)
                ST_OFF: begin
                    tmr_start = 1'b1;
                    tmr_val   = REC_LOAD;
                    c_d.state = ST_RECOVER;
                end
                ST_RECOVER: begin
                    if (tmr_expired) begin
                        tmr_start    = 1'b1;
                        tmr_val      = WIN_LOAD;
                        c_d.state    = ST_TEST;
                        c_d.low_seen = 1'b0;
                    end
                end
                ST_TEST: begin
                    c_d.low_seen = verdict_low;
                    if (tmr_expired) begin
                        if (verdict_low)    c_d.warn = 1'b1;
                        else if (c_q.first) c_d.warn = 1'b0;
                        c_d.first    = 1'b0;
                        c_d.low_seen = 1'b0;
                        tmr_start    = 1'b1;
                        tmr_val      = INT_LOAD;
                        c_d.state    = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (tmr_expired) begin
                        tmr_start    = 1'b1;
                        tmr_val      = WIN_LOAD;
                        c_d.state    = ST_TEST;
                        c_d.low_seen = 1'b0;
                    end
                end
                default: c_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state    <= ST_OFF;
            c_q.warn     <= 1'b0;
            c_q.first    <= 1'b1;
            c_q.low_seen <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign load_en = (c_q.state == ST_TEST) && pwr_ok;
    assign warn    = c_q.warn;

    // R9: no load without a valid supply
    a_r9_load_off_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> !load_en);

    // R9: warning frozen while the supply was missing
    a_r9_warn_hold_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_ok) |-> $stable(c_q.warn));

    // R5: warning only rises when a window closes
    a_r5_warn_rise_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.warn) |-> ($past(c_q.state) == ST_TEST));

    // R7: warning only falls when a power-up window closes
    a_r7_warn_fall_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.warn) |-> ($past(c_q.state) == ST_TEST && $past(c_q.first)));

    // R2: a window is entered only from recovery or the interval wait
    a_r2_test_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_TEST && $past(c_q.state) != ST_TEST)
            |-> ($past(c_q.state) == ST_RECOVER || $past(c_q.state) == ST_WAIT));
endmodule

// File: rtl/batt_health_mon.sv
module batt_health_mon #(
    parameter longint unsigned REC_CYCLES      = 64'd10_000_000,
    parameter longint unsigned WINDOW_CYCLES   = 64'd50_000_000,
    parameter longint unsigned INTERVAL_CYCLES = 64'd4_320_000_000_000,
    parameter int              SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic batt_low_raw,
    output logic load_en,
    output logic warn_pull_low
);
    localparam longint unsigned MAX_A =
        (REC_CYCLES > WINDOW_CYCLES) ? REC_CYCLES : WINDOW_CYCLES;
    localparam longint unsigned MAX_CYC =
        (MAX_A > INTERVAL_CYCLES) ? MAX_A : INTERVAL_CYCLES;
    localparam int CW = $clog2(MAX_CYC + 1);

    logic          batt_low_s;
    logic          tmr_start;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;

    bhm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (batt_low_raw),
        .dout (batt_low_s)
    );

    bhm_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .start_val(tmr_val),
        .expired  (tmr_expired)
    );

    bhm_ctrl #(
        .CW             (CW),
        .REC_CYCLES     (REC_CYCLES),
        .WINDOW_CYCLES  (WINDOW_CYCLES),
        .INTERVAL_CYCLES(INTERVAL_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (pwr_ok),
        .batt_low   (batt_low_s),
        .tmr_expired(tmr_expired),
        .tmr_start  (tmr_start),
        .tmr_val    (tmr_val),
        .load_en    (load_en),
        .warn       (warn_pull_low)
    );
endmodule

// File: tb/batt_health_mon_test.sv
module batt_health_mon_test;
    localparam int REC = 5;
    localparam int WIN = 8;
    localparam int INTV = 20;

    logic clk = 1'b0;
    logic rst_n;
    logic pwr_ok;
    logic batt_low_raw;
    logic load_en;
    logic warn_pull_low;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    batt_health_mon #(
        .REC_CYCLES     (REC),
        .WINDOW_CYCLES  (WIN),
        .INTERVAL_CYCLES(INTV)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_ok       (pwr_ok),
        .batt_low_raw (batt_low_raw),
        .load_en      (load_en),
        .warn_pull_low(warn_pull_low)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Supply rises; recovery, then power-up window with given flag.
    // Ends on the first cycle of the interval wait.
    task automatic power_up(input bit flag_bad, input bit exp_warn);
        pwr_ok = 1'b1;
        batt_low_raw = flag_bad;
        for (int s = 1; s <= REC + WIN; s++) begin
            tick();
            if (s <= REC)
                check(load_en == 1'b0, "R2", "load during recovery", load_en, 0);
            else
                check(load_en == 1'b1, "R3", "load in power-up window", load_en, 1);
        end
        tick();
        check(load_en == 1'b0, "R3", "load after power-up window", load_en, 0);
        check(warn_pull_low == exp_warn, "R7", "warn after power-up test",
              warn_pull_low, exp_warn);
        batt_low_raw = 1'b0;
    endtask

    // One interval plus one periodic window. pulse_off: window offset of a
    // one-cycle flag pulse (-1: none). noise: flag high through most of wait.
    task automatic periodic(input int pulse_off, input bit noise, input bit exp_warn,
                            input string req);
        batt_low_raw = noise;
        for (int t = 2; t <= INTV; t++) begin
            tick();
            check(load_en == 1'b0, "R4", "load during interval", load_en, 0);
            if (t == INTV - 2) batt_low_raw = 1'b0;
        end
        batt_low_raw = 1'b0;
        for (int w = 0; w < WIN; w++) begin
            tick();
            check(load_en == 1'b1, "R4", "load in periodic window", load_en, 1);
            batt_low_raw = (w == pulse_off);
        end
        tick();
        batt_low_raw = 1'b0;
        check(load_en == 1'b0, "R3", "load after periodic window", load_en, 0);
        check(warn_pull_low == exp_warn, req, "warn after periodic test",
              warn_pull_low, exp_warn);
    endtask

    task automatic power_down(input int n, input bit exp_warn);
        pwr_ok = 1'b0;
        #1;
        check(load_en == 1'b0, "R9", "load same cycle as supply loss", load_en, 0);
        for (int i = 0; i < n; i++) begin
            tick();
            check(load_en == 1'b0, "R9", "load while unpowered", load_en, 0);
            check(warn_pull_low == exp_warn, "R9", "warn while unpowered",
                  warn_pull_low, exp_warn);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        pwr_ok = 1'b0;
        batt_low_raw = 1'b0;
        repeat (3) tick();
        check(load_en == 1'b0, "R1", "load in reset", load_en, 0);
        check(warn_pull_low == 1'b0, "R1", "warn in reset", warn_pull_low, 0);
        rst_n = 1'b1;
        tick();
        check(load_en == 1'b0, "R1", "load after reset", load_en, 0);
        check(warn_pull_low == 1'b0, "R1", "warn after reset", warn_pull_low, 0);
        repeat (3) begin
            tick();
            check(load_en == 1'b0, "R9", "load with supply off", load_en, 0);
        end

        // R2 R3 R7: first power-up, good battery
        power_up(1'b0, 1'b0);
        // R4: plain interval, good battery
        periodic(-1, 1'b0, 1'b0, "R6");
        // R8: flag high through the wait only
        periodic(-1, 1'b1, 1'b0, "R8");

        // R5 R8 sweep of the pulse offset across the whole window
        for (int o = 0; o < WIN; o++) begin
            bit hit;
            hit = (o <= WIN - 3);
            periodic(o, 1'b0, hit, hit ? "R5" : "R8");
            if (hit) begin
                periodic(-1, 1'b0, 1'b1, "R6");   // sticky on good periodic test
                power_down(3, 1'b1);
                power_up(1'b0, 1'b0);             // R7 power-up clears
            end
        end

        // R7: power-up test with a bad battery sets, retest keeps it, good clears
        power_down(2, 1'b0);
        power_up(1'b1, 1'b1);
        power_down(2, 1'b1);
        power_up(1'b1, 1'b1);
        power_down(2, 1'b1);
        power_up(1'b0, 1'b0);

        // R9: supply lost in the middle of a window with a failing flag
        batt_low_raw = 1'b0;
        for (int t = 2; t <= INTV; t++) tick();
        batt_low_raw = 1'b1;
        repeat (WIN - 3) begin
            tick();
            check(load_en == 1'b1, "R3", "load before abort", load_en, 1);
        end
        power_down(4, 1'b0);
        batt_low_raw = 1'b0;
        // R10: full recovery after abort
        power_up(1'b0, 1'b0);

        // R10: supply lost during recovery restarts the full delay
        power_down(2, 1'b0);
        pwr_ok = 1'b1;
        tick();
        tick();
        check(load_en == 1'b0, "R10", "load in partial recovery", load_en, 0);
        power_down(2, 1'b0);
        power_up(1'b0, 1'b0);

        // R10: supply lost mid-interval; interval count restarts from zero
        for (int t = 2; t <= INTV / 2; t++) tick();
        power_down(2, 1'b0);
        power_up(1'b0, 1'b0);
        periodic(-1, 1'b0, 1'b0, "R10");

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule